// File: doc/BRIEF.md
# Single-Wire Bus Transceiver Mode Controller

This block is the digital control core of a physical-layer device for a single-wire bus that uses a shared ground as its return path. Two mode pins from the host select one of four operating modes. The block turns those pins into a drive-level and slew select for the analog driver. It converts the transmit bit into a driver enable and decides whether the receive output carries bus data or stays released. The analog driver, the bus comparators and the open-drain receive pad are outside the block. They appear here as digital flags: one for a dominant bus, one for a bus at the high-voltage wake level, and one for a detected loss of ground.

A host that is powered down leaves both mode pins low, and the block then sits in sleep. A high-voltage level on the bus raises the regulator enable, which powers the host. It also opens a window in which the receive output follows the bus. Once the high-voltage level goes away, the window and the regulator enable each stay open for their own programmable hold time, so the host has time to select an active mode. If the host never leaves sleep, a wake timeout drops the regulator enable even while the bus stays at the high-voltage level. A new wake then needs the level to fall and rise again.

Top module: `swbus_mode_ctrl`

## Requirements
- R1: The mode pins pass through a two-flop synchroniser, so a change at the pins reaches the outputs on the second rising edge. The code {mode0_i, mode1_i} = 00 means sleep, 01 high-voltage wake, 10 high speed and 11 normal. The resulting drv_sel_o is 2'b00 in sleep, 2'b01 in high speed, 2'b10 in normal and 2'b11 in high-voltage wake.
- R2: During reset and after it, until a synchronised non-sleep code arrives, the block is in sleep: drv_sel_o = 2'b00, cntl_o = 0, rxd_o = 1 and drv_en_o = 0.
- R3: drv_en_o is 1 exactly when txd_i is 0 and the synchronised mode is not sleep.
- R4: In every non-sleep mode, rxd_o equals the inverse of bus_dom_i.
- R5: In sleep with the wake window closed, rxd_o stays 1 whatever bus_dom_i and txd_i do.
- R6: In sleep, each rising edge that samples bus_hv_i high opens the wake window, or keeps it open, and reloads its hold count. While the window is open, rxd_o equals the inverse of bus_dom_i. The window closes on the RX_HOLD-th rising edge after the last edge that sampled bus_hv_i high, unless a non-sleep mode takes over first.
- R7: cntl_o rises on the rising edge that samples bus_hv_i high in sleep. It is 1 on every edge that follows a cycle spent in a non-sleep mode.
- R8: In sleep without a high-voltage level, cntl_o falls on the CL_HOLD-th rising edge after the last edge that sampled bus_hv_i high, or after the last non-sleep cycle.
- R9: In sleep, cntl_o never stays high for more than WAKE_TMO consecutive cycles. When that limit is reached, cntl_o and the wake window both drop, even with bus_hv_i still high. A new wake needs bus_hv_i to be sampled low first.
- R10: load_sw_o is 1 (switch closed) in every mode, and it is 0 exactly while gnd_loss_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode0_i | input | 1 | First mode pin (reads 0 when undriven) |
| mode1_i | input | 1 | Second mode pin (reads 0 when undriven) |
| txd_i | input | 1 | Transmit bit, 0 = dominant |
| bus_dom_i | input | 1 | Comparator flag: bus is dominant |
| bus_hv_i | input | 1 | Comparator flag: bus is at the high-voltage wake level |
| gnd_loss_i | input | 1 | Loss-of-ground flag |
| drv_en_o | output | 1 | Bus driver enable |
| drv_sel_o | output | 2 | Drive level and slew select for the analog driver |
| rxd_o | output | 1 | Receive level, 1 = released |
| cntl_o | output | 1 | Regulator enable |
| load_sw_o | output | 1 | Load switch, 1 = closed |

## Verification
The bench builds the block with RX_HOLD = 4, CL_HOLD = 9 and WAKE_TMO = 30. These values are short enough to reach the end of every hold and the wake timeout many times in one run. They also keep the two hold times different, so a swapped counter shows up. A wake timeout that cuts across a continuous high-voltage level can be reached and then re-armed. The hold windows can be restarted by closely spaced pulses, and they can be cut short by the host selecting an active mode.

// File: rtl/swbus_pkg.sv
// Shared types for the single-wire bus mode controller.
// Assumes: the mode code is {mode0, mode1}. Drive-select codes are what the
// analog driver decodes.
package swbus_pkg;

    // Operating mode, coded as {mode0, mode1}
    typedef enum logic [1:0] {
        MD_SLEEP = 2'b00,
        MD_WAKE  = 2'b01,
        MD_FAST  = 2'b10,
        MD_NORM  = 2'b11
    } swbus_mode_t;

    // Drive level and slew select for the analog driver
    typedef enum logic [1:0] {
        LVL_OFF  = 2'b00,
        LVL_FAST = 2'b01,
        LVL_NORM = 2'b10,
        LVL_HV   = 2'b11
    } swbus_lvl_t;

endpackage

// File: rtl/swbus_mode_sync.sv
// Mode pin synchroniser.
// Does: passes the two mode pins through a STAGES-deep flop chain and hands
// out the decoded mode.
// Assumes: undriven pins are pulled to 0 by the pad, and the chain resets to
// sleep.
module swbus_mode_sync
    import swbus_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode0_i,
    input  logic        mode1_i,
    output swbus_mode_t mode_o
);
    logic [1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first flop samples the raw pins
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 2'b00;
                    else        chain_q[0] <= {mode0_i, mode1_i};
                end
            end else begin : g_next
                // later flops copy the stage before
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 2'b00;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign mode_o = swbus_mode_t'(chain_q[STAGES-1]);

    generate
        if (STAGES >= 2) begin : g_chk
            p_sync_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
                chain_q[STAGES-1] == $past(chain_q[STAGES-2]));
        end
    endgenerate
endmodule

// File: rtl/swbus_drv_path.sv
// Transmit path and load switch.
// Does: turns the transmit bit into a driver enable, picks the drive level
// for the mode, and opens the load switch on ground loss.
// Assumes: txd_i and gnd_loss_i are already clean levels. This path is
// combinational.
module swbus_drv_path
    import swbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  swbus_mode_t mode_i,
    input  logic        txd_i,
    input  logic        gnd_loss_i,
    output logic        drv_en_o,
    output logic [1:0]  drv_sel_o,
    output logic        load_sw_o
);
    swbus_lvl_t lvl;

    // map the operating mode onto a driver level
    always_comb begin
        unique case (mode_i)
            MD_FAST: lvl = LVL_FAST;
            MD_NORM: lvl = LVL_NORM;
            MD_WAKE: lvl = LVL_HV;
            default: lvl = LVL_OFF;
        endcase
    end

    // drive dominant on a low transmit bit, only when the driver is powered
    always_comb begin
        drv_en_o = (lvl != LVL_OFF) && !txd_i;
    end

    assign drv_sel_o = lvl;
    assign load_sw_o = !gnd_loss_i;

    p_no_drive_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_SLEEP) |-> !drv_en_o);
endmodule

// File: rtl/swbus_wake_ctrl.sv
// Sleep-mode wake sequencer.
// Does: raises the regulator enable and opens the receive window on a
// high-voltage bus level during sleep. Each of the two has its own hold time
// after the level goes away, and a wake timeout caps the time awake in sleep.
// Assumes: bus_hv_i is synchronous to clk. RX_HOLD, CL_HOLD and WAKE_TMO are
// all at least 1.
module swbus_wake_ctrl #(
    parameter int RX_HOLD  = 1000,
    parameter int CL_HOLD  = 5000,
    parameter int WAKE_TMO = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    input  logic bus_hv_i,
    output logic rx_win_o,
    output logic cntl_o
);
    localparam int RW = $clog2(RX_HOLD + 1);
    localparam int CW = $clog2(CL_HOLD + 1);
    localparam int TW = $clog2(WAKE_TMO + 1);
    localparam logic [RW-1:0] RX_LOAD  = RW'(RX_HOLD);
    localparam logic [CW-1:0] CL_LOAD  = CW'(CL_HOLD);
    localparam logic [TW-1:0] TMO_LAST = TW'(WAKE_TMO - 1);

    logic          rx_win_q, cntl_q, lock_q;
    logic [RW-1:0] rx_cnt_q;
    logic [CW-1:0] cl_cnt_q;
    logic [TW-1:0] tmo_q;

    // wake state, hold counters and timeout counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_win_q <= 1'b0;
            cntl_q   <= 1'b0;
            lock_q   <= 1'b0;
            rx_cnt_q <= '0;
            cl_cnt_q <= '0;
            tmo_q    <= '0;
        end else if (!sleep_i) begin
            cntl_q   <= 1'b1;
            rx_win_q <= 1'b0;
            rx_cnt_q <= '0;
            cl_cnt_q <= CL_LOAD;
            tmo_q    <= '0;
            lock_q   <= 1'b0;
        end else if (lock_q) begin
            cntl_q   <= 1'b0;
            rx_win_q <= 1'b0;
            if (!bus_hv_i) lock_q <= 1'b0;
        end else if (cntl_q && tmo_q == TMO_LAST) begin
            cntl_q   <= 1'b0;
            rx_win_q <= 1'b0;
            rx_cnt_q <= '0;
            cl_cnt_q <= '0;
            tmo_q    <= '0;
            lock_q   <= 1'b1;
        end else begin
            tmo_q <= cntl_q ? tmo_q + TW'(1) : '0;
            if (bus_hv_i) begin
                cntl_q   <= 1'b1;
                rx_win_q <= 1'b1;
                rx_cnt_q <= RX_LOAD;
                cl_cnt_q <= CL_LOAD;
            end else begin
                if (rx_win_q) begin
                    if (rx_cnt_q <= RW'(1)) begin
                        rx_win_q <= 1'b0;
                        rx_cnt_q <= '0;
                    end else begin
                        rx_cnt_q <= rx_cnt_q - RW'(1);
                    end
                end
                if (cntl_q) begin
                    if (cl_cnt_q <= CW'(1)) begin
                        cntl_q   <= 1'b0;
                        cl_cnt_q <= '0;
                    end else begin
                        cl_cnt_q <= cl_cnt_q - CW'(1);
                    end
                end
            end
        end
    end

    assign rx_win_o = rx_win_q;
    assign cntl_o   = cntl_q;

    p_cntl_awake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |=> cntl_q);
    p_cntl_fall_asleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cntl_q) |-> $past(sleep_i));
    p_win_open_on_hv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_win_q) |-> $past(bus_hv_i && sleep_i));
    p_lock_after_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(cntl_q));
endmodule

// File: rtl/swbus_mode_ctrl.sv
// Top of the single-wire bus mode controller.
// Does: joins the mode synchroniser, the transmit path and the wake
// sequencer, and steers the receive output.
// Assumes: analog comparator flags arrive as clean synchronous levels, and
// rxd_o = 1 means the open-drain pad is released.
module swbus_mode_ctrl
    import swbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RX_HOLD     = 1000,
    parameter int CL_HOLD     = 5000,
    parameter int WAKE_TMO    = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode0_i,
    input  logic       mode1_i,
    input  logic       txd_i,
    input  logic       bus_dom_i,
    input  logic       bus_hv_i,
    input  logic       gnd_loss_i,
    output logic       drv_en_o,
    output logic [1:0] drv_sel_o,
    output logic       rxd_o,
    output logic       cntl_o,
    output logic       load_sw_o
);
    swbus_mode_t mode;
    logic        sleep;
    logic        rx_win;

    swbus_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode0_i (mode0_i),
        .mode1_i (mode1_i),
        .mode_o  (mode)
    );

    assign sleep = (mode == MD_SLEEP);

    swbus_drv_path u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .txd_i      (txd_i),
        .gnd_loss_i (gnd_loss_i),
        .drv_en_o   (drv_en_o),
        .drv_sel_o  (drv_sel_o),
        .load_sw_o  (load_sw_o)
    );

    swbus_wake_ctrl #(
        .RX_HOLD  (RX_HOLD),
        .CL_HOLD  (CL_HOLD),
        .WAKE_TMO (WAKE_TMO)
    ) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_i  (sleep),
        .bus_hv_i (bus_hv_i),
        .rx_win_o (rx_win),
        .cntl_o   (cntl_o)
    );

    // pass bus data when awake or inside the wake window, else release
    always_comb begin
        if (!sleep || rx_win) rxd_o = !bus_dom_i;
        else                  rxd_o = 1'b1;
    end

    p_rx_quiet_sleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !rx_win) |-> rxd_o);
endmodule

// File: tb/test_swbus_mode_ctrl.sv
module test_swbus_mode_ctrl;
    localparam int RXH = 4;
    localparam int CLH = 9;
    localparam int TMO = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m0 = 1'b0, m1 = 1'b0, txd = 1'b1, dom = 1'b0, hv = 1'b0, gnd = 1'b0;
    logic drv_en, rxd, cntl, load_sw;
    logic [1:0] drv_sel;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    swbus_mode_ctrl #(
        .SYNC_STAGES(2), .RX_HOLD(RXH), .CL_HOLD(CLH), .WAKE_TMO(TMO)
    ) i_swbus_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .mode0_i(m0), .mode1_i(m1), .txd_i(txd),
        .bus_dom_i(dom), .bus_hv_i(hv), .gnd_loss_i(gnd),
        .drv_en_o(drv_en), .drv_sel_o(drv_sel), .rxd_o(rxd),
        .cntl_o(cntl), .load_sw_o(load_sw)
    );

    // reference model: pin history queue plus integer timers
    int pins_q[$];
    int cur_mode = 0;
    bit m_win = 0, m_cntl = 0, m_lock = 0;
    int m_rx_left = 0, m_cl_left = 0, m_awake = 0;

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            pins_q = '{0, 0};
            m_win = 0; m_cntl = 0; m_lock = 0;
            m_rx_left = 0; m_cl_left = 0; m_awake = 0;
        end else begin
            if (cur_mode != 0) begin
                m_cntl = 1; m_win = 0; m_lock = 0;
                m_cl_left = CLH; m_rx_left = 0; m_awake = 0;
            end else if (m_lock) begin
                m_cntl = 0; m_win = 0;
                if (!hv) m_lock = 0;
            end else if (m_cntl && m_awake == TMO - 1) begin
                m_cntl = 0; m_win = 0; m_lock = 1; m_awake = 0;
            end else begin
                m_awake = m_cntl ? m_awake + 1 : 0;
                if (hv) begin
                    m_cntl = 1; m_win = 1; m_rx_left = RXH; m_cl_left = CLH;
                end else begin
                    if (m_win) begin
                        m_rx_left--;
                        if (m_rx_left <= 0) m_win = 0;
                    end
                    if (m_cntl) begin
                        m_cl_left--;
                        if (m_cl_left <= 0) m_cntl = 0;
                    end
                end
            end
            pins_q.push_back({m0, m1});
            void'(pins_q.pop_front());
        end
        cur_mode = pins_q[0];
    end

    // compare every cycle, well after the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            int sel_exp;
            bit awake_exp;
            case (cur_mode)
                0: sel_exp = 0;
                2: sel_exp = 1;
                3: sel_exp = 2;
                default: sel_exp = 3;
            endcase
            awake_exp = (cur_mode != 0);
            check("R1", "drv_sel", drv_sel, sel_exp);
            check("R3", "drv_en", drv_en, (awake_exp && !txd) ? 1 : 0);
            if (awake_exp)  check("R4", "rxd", rxd, !dom);
            else if (m_win) check("R6", "rxd", rxd, !dom);
            else            check("R5", "rxd", rxd, 1);
            check("R8", "cntl", cntl, m_cntl);
            check("R10", "load_sw", load_sw, !gnd);
        end
    end

    task automatic drive(input bit a, input bit b, input bit t, input bit d, input bit h, input bit g);
        @(negedge clk);
        m0 = a; m1 = b; txd = t; dom = d; hv = h; gnd = g;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    initial begin
        // mode pins already active during reset
        m0 = 1; m1 = 1;
        repeat (4) @(posedge clk);
        #3;
        check("R2", "drv_sel in reset", drv_sel, 0);
        check("R2", "cntl in reset", cntl, 0);
        check("R2", "rxd in reset", rxd, 1);
        @(negedge clk);
        rst_n = 1;
        wait_cyc(1);
        check("R2", "drv_sel after reset", drv_sel, 0);
        check("R2", "cntl after reset", cntl, 0);
        wait_cyc(1);
        check("R1", "normal after sync", drv_sel, 2);

        // sleep, no high voltage: receive stays released
        for (int i = 0; i < 16; i++) drive(0, 0, i[0], i[1], 0, 0);
        wait_cyc(CLH + 2);
        for (int i = 0; i < 8; i++) begin
            drive(0, 0, i[0], i[1], 0, 0);
            wait_cyc(0);
            #1 check("R5", "rxd sleep quiet", rxd, 1);
        end
        check("R8", "cntl low after hold", cntl, 0);

        // short wake pulse
        drive(0, 0, 1, 1, 1, 0);
        wait_cyc(1);
        check("R7", "cntl on wake", cntl, 1);
        check("R6", "rxd follows in window", rxd, 0);
        for (int i = 0; i < 3; i++) drive(0, 0, 1, i[0], 1, 0);
        for (int i = 0; i < 20; i++) drive(0, 0, 1, i[0], 0, 0);
        check("R8", "cntl after wake hold", cntl, 0);

        // restarting pulses
        for (int k = 0; k < 6; k++) begin
            drive(0, 0, 1, 1, 1, 0);
            for (int i = 0; i < 3; i++) drive(0, 0, 1, i[1], 0, 0);
        end
        for (int i = 0; i < 20; i++) drive(0, 0, 1, i[0], 0, 0);

        // continuous high voltage beyond the wake timeout
        for (int i = 0; i < TMO + 8; i++) drive(0, 0, 1, i[0], 1, 0);
        wait_cyc(0);
        check("R9", "cntl after timeout", cntl, 0);
        for (int i = 0; i < 2; i++) drive(0, 0, 1, 0, 0, 0);
        drive(0, 0, 1, 1, 1, 0);
        wait_cyc(1);
        check("R9", "cntl re-armed", cntl, 1);
        for (int i = 0; i < CLH + 4; i++) drive(0, 0, 1, i[0], 0, 0);

        // wake, then host selects normal during the hold
        drive(0, 0, 1, 1, 1, 0);
        drive(0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 12; i++) drive(1, 1, i[0], i[1], 0, 0);
        check("R7", "cntl held by host", cntl, 1);

        // each active mode with transmit and bus patterns
        for (int mc = 1; mc < 4; mc++) begin
            for (int i = 0; i < 24; i++)
                drive(mc[1], mc[0], i[0], i[1] ^ i[2], i[3], i[4]);
        end
        check("R7", "cntl in active modes", cntl, 1);

        // back to sleep: cntl holds then drops
        for (int i = 0; i < CLH + 6; i++) drive(0, 0, i[0], i[1], 0, i[2]);
        check("R8", "cntl after host sleep", cntl, 0);

        // ground loss in sleep and active
        drive(0, 0, 1, 0, 0, 1);
        wait_cyc(0);
        #1 check("R10", "switch open sleep", load_sw, 0);
        drive(1, 0, 1, 0, 0, 1);
        wait_cyc(3);
        check("R10", "switch open fast", load_sw, 0);
        check("R1", "fast select", drv_sel, 1);
        drive(0, 1, 0, 1, 1, 0);
        wait_cyc(3);
        check("R10", "switch closed", load_sw, 1);
        check("R1", "hv select", drv_sel, 3);
        check("R3", "driver on", drv_en, 1);
        for (int i = 0; i < 20; i++) drive(0, 0, 1, 0, 0, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule